// File: doc/BRIEF.md
# Sniffer event message serial transmitter

This block reports card-interface events to a host over one asynchronous serial transmit line. Two kinds of event are reported. The first is a character that the bus receiver has captured, which arrives as a one-cycle strobe with its data and status fields. The second is a change of the synchronized card reset level, in either direction. Each event becomes a fixed 16-bit word, and the word goes out as two serial bytes with no gap between them.

A small first-in first-out queue sits between the event sources and the serializer. A character and a reset change can arrive in the same cycle, and events can arrive while a word is still going out. The queue keeps all of them, in order. The bit timer divides the system clock by a fixed count, so a 12 MHz clock gives 3 Mbit/s.

Top module: `evt_uart_tx`

## Requirements
- R1: The transmit line is high while reset is asserted and whenever nothing is pending. The reset level present when reset is released produces no message.
- R2: A character word has bit 15 = 0, bit 14 = 1, bits 13..11 = 0, bit 10 = error flag, bit 9 = start-bit midpoint sample, bit 8 = parity, and bits 7..0 = data.
- R3: Every rise and every fall of the reset level produces a word with bit 15 = 1, bit 14 = the new level, and bits 13..0 = 0.
- R4: Each byte is framed as a low start bit, eight data bits sent least significant bit first, and a high stop bit. Bits 7..0 of the word go out in the first byte and bits 15..8 in the second.
- R5: Every serial bit lasts exactly DIV clock cycles (DIV = 4 by default).
- R6: The start bit of the second byte follows the first byte's stop bit at once, with no idle time.
- R7: A character strobe and a reset change in the same cycle both produce a word, and the character word is sent first.
- R8: Words are sent in arrival order. With DEPTH = 4, a burst of DEPTH+1 events over three cycles is delivered completely, and the queue count never exceeds DEPTH.
- R9: The character field inputs have no effect while the character strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chr_vld_i | input | 1 | One-cycle strobe: a character was captured |
| chr_err_i | input | 1 | Error signal detected during the character |
| chr_start_i | input | 1 | Line value sampled at the midpoint of the start bit |
| chr_par_i | input | 1 | Received parity bit |
| chr_data_i | input | 8 | Received data bits, unmodified |
| rst_lvl_i | input | 1 | Synchronized card reset level |
| tx_o | output | 1 | Serial transmit line to the host |

## Verification
A corrupted bit or divider counter inside the serializer shows up within a single frame. A wrong counter makes a bit shorter or longer than four cycles, misplaces the second start bit, or changes the stop bit, and the bench samples every cycle of all 80 cycles of each frame. A bad queue pointer or count shows up later, when the word is delivered: a word arrives out of order, a word is lost, or an extra frame appears. For this reason the bench compares every decoded frame with its own queue of expected words, and it flags any frame it did not expect. A fault in the edge detector appears either as a frame after reset release that should not be there, or as a missing reset-change frame within about 80 cycles of the change.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int EVT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * (BYTE_W + 2);

  typedef logic [EVT_W-1:0] evt_word_t;

  function automatic evt_word_t mk_chr_word(input logic err, input logic stb,
                                            input logic par, input logic [BYTE_W-1:0] dat);
    return {1'b0, 1'b1, 3'b000, err, stb, par, dat};
  endfunction

  function automatic evt_word_t mk_rst_word(input logic lvl);
    return {1'b1, lvl, 14'd0};
  endfunction

  // two 8N1 bytes, low byte first, packed LSB-first for shifting
  function automatic logic [FRAME_W-1:0] mk_frame(input evt_word_t w);
    return {1'b1, w[15:8], 1'b0, 1'b1, w[7:0], 1'b0};
  endfunction
endpackage

// File: rtl/evt_edge.sv
module evt_edge
  import evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  output logic      evt_o,
  output evt_word_t word_o
);
  logic lvl_q, primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lvl_q    <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  // first cycle after reset only captures the level
  assign evt_o  = primed_q && (lvl_i != lvl_q);
  assign word_o = mk_rst_word(lvl_i);
endmodule

// File: rtl/evt_queue.sv
module evt_queue
  import evt_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_vld_i,
  input  evt_word_t     a_word_i,
  input  logic          b_vld_i,
  input  evt_word_t     b_word_i,
  input  logic          pop_i,
  output evt_word_t     rd_word_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  evt_word_t       mem_q [DEPTH];
  logic [PW-1:0]   wptr_q, rptr_q;
  logic [CW-1:0]   cnt_q;
  logic            acc_a, acc_b, do_pop;

  // port a has priority and lands in the older slot
  always_comb begin
    acc_a  = a_vld_i && (cnt_q < CW'(DEPTH));
    acc_b  = b_vld_i && ((cnt_q + CW'(acc_a)) < CW'(DEPTH));
    do_pop = pop_i && (cnt_q != '0);
  end

  always_ff @(posedge clk_i) begin
    if (acc_a) mem_q[wptr_q] <= a_word_i;
    if (acc_b) mem_q[wptr_q + PW'(acc_a)] <= b_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + PW'(acc_a) + PW'(acc_b);
      rptr_q <= rptr_q + PW'(do_pop);
      cnt_q  <= cnt_q + CW'(acc_a) + CW'(acc_b) - CW'(do_pop);
    end
  end

  assign rd_word_o = mem_q[rptr_q];
  assign empty_o   = (cnt_q == '0);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/evt_serial.sv
module evt_serial
  import evt_pkg::*;
#(
  parameter int DIV = 4,
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int BW = $clog2(FRAME_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_i,
  input  evt_word_t     word_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic [DW-1:0] div_o,
  output logic          tx_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [DW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic               busy_q;

  assign pop_o = !busy_q && pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (pend_i) begin
        sh_q   <= mk_frame(word_i);
        div_q  <= '0;
        bit_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (div_q == DW'(DIV - 1)) begin
      div_q <= '0;
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      if (bit_q == BW'(FRAME_W - 1)) busy_q <= 1'b0;
      else                           bit_q  <= bit_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign div_o  = div_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/evt_uart_tx.sv
module evt_uart_tx
  import evt_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int DEPTH = 4,
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chr_vld_i,
  input  logic       chr_err_i,
  input  logic       chr_start_i,
  input  logic       chr_par_i,
  input  logic [7:0] chr_data_i,
  input  logic       rst_lvl_i,
  output logic       tx_o
);
  logic          edge_evt, q_empty, ser_pop, ser_busy;
  evt_word_t     edge_word, chr_word, q_word;
  logic [CW-1:0] q_cnt;
  logic [DW-1:0] ser_div;

  assign chr_word = mk_chr_word(chr_err_i, chr_start_i, chr_par_i, chr_data_i);

  evt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (rst_lvl_i),
    .evt_o  (edge_evt),
    .word_o (edge_word)
  );

  evt_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_vld_i   (chr_vld_i),
    .a_word_i  (chr_word),
    .b_vld_i   (edge_evt),
    .b_word_i  (edge_word),
    .pop_i     (ser_pop),
    .rd_word_o (q_word),
    .empty_o   (q_empty),
    .cnt_o     (q_cnt)
  );

  evt_serial #(.DIV(DIV)) u_serial (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (!q_empty),
    .word_i (q_word),
    .pop_o  (ser_pop),
    .busy_o (ser_busy),
    .div_o  (ser_div),
    .tx_o   (tx_o)
  );
endmodule

// File: rtl/evt_uart_tx_chk.sv
module evt_uart_tx_chk #(
  parameter int DIV   = 4,
  parameter int DEPTH = 4,
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_i,
  input logic          busy_i,
  input logic [DW-1:0] div_i,
  input logic [CW-1:0] cnt_i
);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> tx_i);

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !tx_i);

  p_bit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && div_i != '0) |-> $stable(tx_i));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));

  p_prompt_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cnt_i != '0) |=> busy_i);
endmodule

bind evt_uart_tx evt_uart_tx_chk #(.DIV(DIV), .DEPTH(DEPTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tx_i   (tx_o),
  .busy_i (ser_busy),
  .div_i  (ser_div),
  .cnt_i  (q_cnt)
);

// File: tb/evt_uart_tx_tb.sv
module evt_uart_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NBIT = 20;
  localparam int FLEN = DIV * NBIT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_vld = 1'b0, chr_err = 1'b0, chr_start = 1'b0, chr_par = 1'b0;
  logic [7:0] chr_data = 8'h00;
  logic rst_lvl = 1'b1;
  logic tx;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_uart_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chr_vld_i(chr_vld), .chr_err_i(chr_err),
    .chr_start_i(chr_start), .chr_par_i(chr_par), .chr_data_i(chr_data),
    .rst_lvl_i(rst_lvl), .tx_o(tx)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [15:0] chr_w(input logic e, input logic s, input logic p, input logic [7:0] d);
    return {1'b0, 1'b1, 3'b000, e, s, p, d};
  endfunction

  // frame monitor: samples every cycle of each frame at negedge
  initial begin
    logic s [FLEN+1];
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        logic [15:0] w;
        logic stab;
        s[0] = 1'b0;
        for (int i = 1; i <= FLEN; i++) begin
          @(negedge clk);
          s[i] = tx;
        end
        stab = 1'b1;
        for (int k = 0; k < NBIT; k++)
          for (int j = 1; j < DIV; j++)
            if (s[k*DIV+j] != s[k*DIV]) stab = 1'b0;
        chk(stab, "R5 bit duration", {31'd0, stab}, 32'd1);
        chk(s[9*DIV] == 1'b1 && s[19*DIV] == 1'b1, "R4 stop bits",
            {s[9*DIV], s[19*DIV]}, 32'h3);
        chk(s[10*DIV] == 1'b0, "R6 second start without gap", {31'd0, s[10*DIV]}, 32'd0);
        chk(s[FLEN] == 1'b1, "R1 idle after frame", {31'd0, s[FLEN]}, 32'd1);
        for (int b = 0; b < 8; b++) begin
          w[b]   = s[(1 + b) * DIV + 2];
          w[8+b] = s[(11 + b) * DIV + 2];
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1/R9 unexpected frame", {16'd0, w}, 32'hffff);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(w == e, e[15] ? "R3/R4/R8 rst word" : "R2/R4/R8 chr word", {16'd0, w}, {16'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (FLEN + 4) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic drive_chr(input logic [7:0] d, input logic e, input logic s, input logic p);
    chr_vld = 1'b1; chr_data = d; chr_err = e; chr_start = s; chr_par = p;
    exp_q.push_back(chr_w(e, s, p, d));
  endtask

  initial begin
    bit idle_ok;
    // R1: reset state, and the level held at reset release gives no message
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R1 tx high in reset", {31'd0, tx}, 32'd1);
    rst_n = 1'b1;
    idle_ok = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (tx != 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, "R1 no message for level at reset release", {31'd0, idle_ok}, 32'd1);

    // R3: falling and rising edges
    rst_lvl = 1'b0; exp_q.push_back({1'b1, 1'b0, 14'd0});
    drain("R3 falling edge delivered");
    rst_lvl = 1'b1; exp_q.push_back({1'b1, 1'b1, 14'd0});
    drain("R3 rising edge delivered");

    // R2/R4: sweep all data values with rotating flag patterns
    for (int i = 0; i < 256; i++) begin
      drive_chr(i[7:0], i[0], i[1], i[2] ^ i[5]);
      @(negedge clk);
      chr_vld = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
    end
    drain("R2 character sweep delivered");

    // R9: fields toggle without strobe
    idle_ok = 1'b1;
    for (int i = 0; i < 120; i++) begin
      chr_data = i[7:0] ^ 8'h5a; chr_err = i[0]; chr_start = i[1]; chr_par = i[2];
      @(negedge clk);
      if (tx != 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, "R9 fields ignored without strobe", {31'd0, idle_ok}, 32'd1);

    // R7: character and reset change in the same cycle, character first
    drive_chr(8'hc3, 1'b1, 1'b0, 1'b1);
    rst_lvl = 1'b0; exp_q.push_back({1'b1, 1'b0, 14'd0});
    @(negedge clk);
    chr_vld = 1'b0;
    drain("R7 simultaneous events both sent");
    drive_chr(8'h3c, 1'b0, 1'b1, 1'b0);
    rst_lvl = 1'b1; exp_q.push_back({1'b1, 1'b1, 14'd0});
    @(negedge clk);
    chr_vld = 1'b0;
    drain("R7 simultaneous events on rising edge");

    // R8: DEPTH+1 events in three consecutive cycles
    drive_chr(8'h11, 1'b0, 1'b0, 1'b0);
    rst_lvl = 1'b0; exp_q.push_back({1'b1, 1'b0, 14'd0});
    @(negedge clk);
    drive_chr(8'h22, 1'b1, 1'b1, 1'b1);
    rst_lvl = 1'b1; exp_q.push_back({1'b1, 1'b1, 14'd0});
    @(negedge clk);
    drive_chr(8'h33, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chr_vld = 1'b0;
    drain("R8 burst fully delivered in order");

    // R8: back-to-back character stream, one per cycle
    for (int i = 0; i < 5; i++) begin
      drive_chr(8'(8'hf0 + i), i[0], 1'b0, i[1]);
      @(negedge clk);
    end
    chr_vld = 1'b0;
    drain("R8 character stream delivered");

    summary();
  end
endmodule